// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block is a watchdog for a system bus. A 7-bit counter counts down at a rate set by a 2-bit prescaler select. Once software has turned the watchdog on, the counter must be reloaded before bit 6 of the counter drops to zero. A reload is also refused while the counter is still above a programmed window value. If either rule is broken, the block pulses a reset request for one clock.

One step before the deadline, an optional early warning flag raises an interrupt. This gives software a last chance to log data or to reload the counter. Software reloads the counter and reads the state through three small registers, using either 16-bit or 32-bit accesses.

Register map. Bits [3:2] of the address select the register: 0x0 control, 0x4 configuration, 0x8 status. The fields are:

- Control: bits [6:0] are the counter; bit 7 is the enable.
- Configuration: bits [6:0] are the window; bit 8 is the warning enable; bits [13:12] are the prescaler select P.
- Status: bit 0 is the warning flag.

Every other bit reads as zero. The counter steps once every BASE_DIV × 2^P clocks, with BASE_DIV = 4096 by default.

Top module: `wdog_win`

## Requirements
- R1: After reset the control register reads 0x0000007F, the configuration register reads 0x0000007F, the status register reads 0, and irq_early and rst_req are low.
- R2: Writing 1 to control bit 7 turns the watchdog on. Writing 0 there leaves it on, and only reset turns it off. While it is off, the counter still runs through 0x40 to 0x3F, but rst_req stays low.
- R3: The counter steps down once every BASE_DIV × 2^P clocks, counted from the last control write or the last step. The prescaler select is read from configuration bits [13:12].
- R4: While enabled, the step from 0x40 to 0x3F makes rst_req high for exactly the next clock.
- R5: While the warning enable (configuration bit 8) is 1, the step from 0x41 to 0x40 sets status bit 0, and irq_early equals status bit 0.
- R6: Writing status with bit 0 = 0 clears the flag. Writing 1 there has no effect.
- R7: A control write made while enabled, with the counter above the window field (configuration bits [6:0]), raises rst_req in the next clock. The counter still takes the written value.
- R8: A control write made while enabled whose bit 6 is 0 raises rst_req in the next clock.
- R9: The warning enable can be set by a configuration write, and only reset clears it. The window and prescaler fields take each written value.
- R10: A write with word_acc = 1, or a 16-bit write with addr[1] = 0, updates the register. A 16-bit access with addr[1] = 1 writes nothing and reads 0.
- R11: When a control write and a counter step fall in the same clock, the write wins. A warning set beats a status clear in the same clock. The counter wraps from 0x00 to 0x7F and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one clock |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| word_acc | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| rdata | output | 32 | Read data for addr, combinational |
| irq_early | output | 1 | Early warning interrupt |
| rst_req | output | 1 | One-clock system reset request |

## Verification
The hardest cases to reach are the ones where several events fall in the same clock:

- a counter step and a control write;
- the warning set and a status clear;
- a prescaler change while the phase count is already past the new limit.

These only line up after precise waiting through long count intervals. The bench shrinks BASE_DIV to 4 so the counter reaches 0x41 and 0x40 within a few hundred clocks. It then runs deliberate phases: disabled underflow, window violation, bit-6-zero reload, and 16-bit lane writes. A long pseudo-random run of mixed accesses follows, with a reference model compared on every clock, so these same-clock collisions happen many times.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CNT_W  = 7;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    localparam logic [CNT_W-1:0] CNT_INIT  = 7'h7F;
    localparam logic [CNT_W-1:0] WIN_INIT  = 7'h7F;
    localparam logic [CNT_W-1:0] WARN_FROM = 7'h41;
    localparam logic [CNT_W-1:0] FIRE_FROM = 7'h40;

    localparam int CTRL_ACT_BIT = 7;
    localparam int CTRL_MSB_BIT = 6;
    localparam int CFG_WEN_BIT  = 8;
    localparam int CFG_PS_LSB   = 12;
    localparam int STAT_FLG_BIT = 0;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] window;
        logic [1:0]       presc;
        logic             warn_en;
    } cfg_t;

    typedef struct packed {
        logic             ctrl_wr;
        logic             cfg_wr;
        logic             stat_wr;
        logic [CNT_W-1:0] cnt_val;
        logic             act_set;
        cfg_t             cfg_val;
        logic             flag_keep;
    } wr_req_t;

    function automatic logic lane_low(input logic [ADDR_W-1:0] a, input logic word);
        return word | ~a[1];
    endfunction

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[3:2]);
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input logic act, input logic [CNT_W-1:0] c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CTRL_ACT_BIT] = act;
        v[CNT_W-1:0]    = c;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cfg(input cfg_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CNT_W-1:0]               = c.window;
        v[CFG_WEN_BIT]             = c.warn_en;
        v[CFG_PS_LSB+1:CFG_PS_LSB] = c.presc;
        return v;
    endfunction

endpackage

// File: rtl/wdog_bus.sv
module wdog_bus
    import wdog_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              word_acc,
    input  logic              active,
    input  logic [CNT_W-1:0]  cnt,
    input  cfg_t              cfg,
    input  logic              flag,
    output wr_req_t           wq,
    output logic [DATA_W-1:0] rdata
);

    reg_sel_e sel;
    logic     lane_ok;
    logic     unused_bits;

    assign sel     = decode(addr);
    assign lane_ok = lane_low(addr, word_acc);

    always_comb begin
        wq.ctrl_wr   = wr_en && lane_ok && (sel == SEL_CTRL);
        wq.cfg_wr    = wr_en && lane_ok && (sel == SEL_CFG);
        wq.stat_wr   = wr_en && lane_ok && (sel == SEL_STAT);
        wq.cnt_val   = wdata[CNT_W-1:0];
        wq.act_set   = wdata[CTRL_ACT_BIT];
        wq.cfg_val.window  = wdata[CNT_W-1:0];
        wq.cfg_val.warn_en = wdata[CFG_WEN_BIT];
        wq.cfg_val.presc   = wdata[CFG_PS_LSB+1:CFG_PS_LSB];
        wq.flag_keep = wdata[STAT_FLG_BIT];
    end

    always_comb begin
        rdata = '0;
        if (lane_ok) begin
            unique case (sel)
                SEL_CTRL: rdata = pack_ctrl(active, cnt);
                SEL_CFG:  rdata = pack_cfg(cfg);
                SEL_STAT: rdata = {{(DATA_W-1){1'b0}}, flag};
                default:  rdata = '0;
            endcase
        end
    end

    assign unused_bits = ^{wdata[DATA_W-1:CFG_PS_LSB+2], wdata[11:9], addr[0]};

    always_comb begin
        a_r10_upper_lane: assert (!(wq.ctrl_wr || wq.cfg_wr || wq.stat_wr) || word_acc || !addr[1]);
    end

endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wq,
    output cfg_t    cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.window  <= WIN_INIT;
            cfg.presc   <= 2'd0;
            cfg.warn_en <= 1'b0;
        end else if (wq.cfg_wr) begin
            cfg.window  <= wq.cfg_val.window;
            cfg.presc   <= wq.cfg_val.presc;
            cfg.warn_en <= cfg.warn_en | wq.cfg_val.warn_en;
        end
    end

    a_r9_warn_sticky: assert property (@(posedge clk) disable iff (rst)
        cfg.warn_en |=> cfg.warn_en);

endmodule

// File: rtl/wdog_presc.sv
module wdog_presc #(
    parameter int BASE_DIV = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] presc,
    input  logic       restart,
    output logic       tick
);

    localparam int PS_W = $clog2(BASE_DIV * 8) + 1;
    localparam logic [PS_W-1:0] BASE = PS_W'(BASE_DIV);

    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] limit;

    assign limit = (BASE << presc) - PS_W'(1);
    assign tick  = (pcnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PS_W'(1);
        end
    end

    a_r3_restart: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pcnt == '0));

    a_r3_advance: assert property (@(posedge clk) disable iff (rst)
        (!restart && !tick) |=> (pcnt == $past(pcnt) + PS_W'(1)));

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          wq,
    input  cfg_t             cfg,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             active,
    output logic             flag,
    output logic             rst_req
);

    logic act_next;
    logic fire;
    logic warn_hit;

    assign act_next = active | wq.act_set;
    assign warn_hit = tick && !wq.ctrl_wr && (cnt == WARN_FROM) && cfg.warn_en;

    always_comb begin
        if (wq.ctrl_wr) begin
            fire = act_next && ((cnt > cfg.window) || !wq.cnt_val[CTRL_MSB_BIT]);
        end else begin
            fire = tick && active && (cnt == FIRE_FROM);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= CNT_INIT;
            active  <= 1'b0;
            flag    <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= fire;
            if (wq.ctrl_wr) begin
                cnt    <= wq.cnt_val;
                active <= act_next;
            end else if (tick) begin
                cnt <= cnt - 7'd1;
            end
            if (warn_hit) begin
                flag <= 1'b1;
            end else if (wq.stat_wr && !wq.flag_keep) begin
                flag <= 1'b0;
            end
        end
    end

    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        active |=> active);

    a_r2_gate: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> active);

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !wq.ctrl_wr) |=> (cnt == $past(cnt) - 7'd1));

    a_r4_fire: assert property (@(posedge clk) disable iff (rst)
        (tick && !wq.ctrl_wr && active && cnt == FIRE_FROM) |=> rst_req);

    a_r5_flag_needs_en: assert property (@(posedge clk) disable iff (rst)
        flag |-> cfg.warn_en);

    a_r6_keep_on_one: assert property (@(posedge clk) disable iff (rst)
        (flag && wq.stat_wr && wq.flag_keep) |=> flag);

endmodule

// File: rtl/wdog_win.sv
module wdog_win
    import wdog_pkg::*;
#(
    parameter int BASE_DIV = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    input  logic        word_acc,
    output logic [31:0] rdata,
    output logic        irq_early,
    output logic        rst_req
);

    wr_req_t          wq;
    cfg_t             cfg;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             active;
    logic             flag;

    wdog_bus u_bus (
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .word_acc (word_acc),
        .active   (active),
        .cnt      (cnt),
        .cfg      (cfg),
        .flag     (flag),
        .wq       (wq),
        .rdata    (rdata)
    );

    wdog_cfg u_cfg (
        .clk (clk),
        .rst (rst),
        .wq  (wq),
        .cfg (cfg)
    );

    wdog_presc #(.BASE_DIV(BASE_DIV)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .presc   (cfg.presc),
        .restart (wq.ctrl_wr),
        .tick    (tick)
    );

    wdog_core u_core (
        .clk     (clk),
        .rst     (rst),
        .wq      (wq),
        .cfg     (cfg),
        .tick    (tick),
        .cnt     (cnt),
        .active  (active),
        .flag    (flag),
        .rst_req (rst_req)
    );

    assign irq_early = flag;

    a_r1_quiet_reset: assert property (@(posedge clk)
        rst |=> (!rst_req && !irq_early));

endmodule

// File: tb/wdog_win_tb_top.sv
module wdog_win_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TB_BASE    = 4;
    localparam int WD_LIMIT   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = '0;
    logic        word_acc = 1'b1;
    logic [31:0] rdata;
    logic        irq_early;
    logic        rst_req;

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    int m_cnt, m_pc, m_act, m_win, m_ps, m_we, m_flag, m_rst;
    int lim, na, nr;
    bit tk, lo, wc, fc, sc, setf;

    wdog_win #(.BASE_DIV(TB_BASE)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .word_acc(word_acc), .rdata(rdata), .irq_early(irq_early), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_cnt = 127; m_pc = 0; m_act = 0; m_win = 127;
            m_ps = 0; m_we = 0; m_flag = 0; m_rst = 0;
        end else begin
            lim  = (TB_BASE << m_ps) - 1;
            tk   = (m_pc >= lim);
            lo   = word_acc || !addr[1];
            wc   = wr_en && lo && (addr[3:2] == 2'd0);
            fc   = wr_en && lo && (addr[3:2] == 2'd1);
            sc   = wr_en && lo && (addr[3:2] == 2'd2);
            nr   = 0;
            setf = 0;
            if (wc) begin
                na = m_act | int'(wdata[7]);
                if (na != 0 && (m_cnt > m_win || !wdata[6])) nr = 1;
                m_cnt = int'(wdata[6:0]);
                m_act = na;
                m_pc  = 0;
            end else if (tk) begin
                if (m_cnt == 65 && m_we != 0) setf = 1;
                if (m_cnt == 64 && m_act != 0) nr = 1;
                m_cnt = (m_cnt + 127) % 128;
                m_pc  = 0;
            end else begin
                m_pc = m_pc + 1;
            end
            if (fc) begin
                m_win = int'(wdata[6:0]);
                if (wdata[8]) m_we = 1;
                m_ps = int'(wdata[13:12]);
            end
            if (setf) m_flag = 1;
            else if (sc && !wdata[0]) m_flag = 0;
            m_rst = nr;
        end
    end

    function automatic logic [31:0] model_rd(input logic [3:0] a, input logic w);
        logic [31:0] v;
        v = '0;
        if (w || !a[1]) begin
            case (a[3:2])
                2'd0: begin v[7] = (m_act != 0); v[6:0] = 7'(m_cnt); end
                2'd1: begin v[6:0] = 7'(m_win); v[8] = (m_we != 0); v[13:12] = 2'(m_ps); end
                2'd2: v[0] = (m_flag != 0);
                default: v = '0;
            endcase
        end
        return v;
    endfunction

    always @(negedge clk) begin
        if (started && !done) begin
            logic [31:0] exp_rd;
            exp_rd = model_rd(addr, word_acc);
            checks = checks + 3;
            if (rst_req !== (m_rst != 0)) begin
                errors++;
                $display("FAIL %s rst_req actual %0b expected %0b (cycle %0d)", cur_req, rst_req, m_rst, cyc);
            end
            if (irq_early !== (m_flag != 0)) begin
                errors++;
                $display("FAIL %s irq_early actual %0b expected %0b (cycle %0d)", cur_req, irq_early, m_flag, cyc);
            end
            if (rdata !== exp_rd) begin
                errors++;
                $display("FAIL %s rdata@%h actual %h expected %h (cycle %0d)", cur_req, addr, rdata, exp_rd, cyc);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic do_wr(input logic [3:0] a, input logic [31:0] d, input logic w, input string rq);
        cur_req = rq; addr = a; wdata = d; word_acc = w; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic run(input int n, input logic [3:0] a, input logic w, input string rq);
        cur_req = rq; addr = a; word_acc = w;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state and R10 upper-lane reads
        run(3, 4'h0, 1'b1, "R1");
        run(2, 4'h4, 1'b1, "R1");
        run(2, 4'h8, 1'b1, "R1");
        run(2, 4'h2, 1'b0, "R10");
        run(2, 4'h4, 1'b0, "R10");
        // R2 disabled: counter passes 0x40 -> 0x3F with no request
        run(300, 4'h0, 1'b1, "R2");
        // R9 enable warning, window 0x7F, presc 0
        do_wr(4'h4, 32'h0000_017F, 1'b1, "R9");
        run(2, 4'h4, 1'b1, "R9");
        // R5/R4 enable with counter 0x45, run through warning and underflow
        do_wr(4'h0, 32'h0000_00C5, 1'b1, "R5");
        run(22, 4'h0, 1'b1, "R5");
        run(8, 4'h0, 1'b1, "R4");
        run(2, 4'h8, 1'b1, "R5");
        // R6 clear semantics
        do_wr(4'h8, 32'h0000_0001, 1'b1, "R6");
        run(2, 4'h8, 1'b1, "R6");
        do_wr(4'h8, 32'h0000_0000, 1'b1, "R6");
        run(2, 4'h8, 1'b1, "R6");
        // R2 writing 0 to enable leaves it on
        do_wr(4'h0, 32'h0000_007F, 1'b1, "R2");
        run(4, 4'h0, 1'b1, "R2");
        // R9 window 0x50, warning enable written 0 stays set
        do_wr(4'h4, 32'h0000_0050, 1'b1, "R9");
        run(2, 4'h4, 1'b1, "R9");
        // R7 reload above window
        do_wr(4'h0, 32'h0000_007F, 1'b1, "R7");
        run(3, 4'h0, 1'b1, "R7");
        run(200, 4'h0, 1'b1, "R3");
        do_wr(4'h0, 32'h0000_007F, 1'b1, "R7");
        run(3, 4'h0, 1'b1, "R7");
        // R8 reload with bit 6 clear
        do_wr(4'h4, 32'h0000_017F, 1'b1, "R8");
        do_wr(4'h0, 32'h0000_0030, 1'b1, "R8");
        run(3, 4'h0, 1'b1, "R8");
        // R10 upper halfword writes ignored, lower halfword write taken
        do_wr(4'h2, 32'h0000_0000, 1'b0, "R10");
        run(2, 4'h0, 1'b1, "R10");
        do_wr(4'h6, 32'h0000_0000, 1'b0, "R10");
        run(2, 4'h4, 1'b1, "R10");
        do_wr(4'h4, 32'h0000_207F, 1'b0, "R10");
        run(2, 4'h4, 1'b1, "R10");
        // R3 period with presc 2 and 3, phase restart on reload
        run(80, 4'h0, 1'b1, "R3");
        do_wr(4'h0, 32'h0000_0070, 1'b1, "R3");
        run(30, 4'h0, 1'b1, "R3");
        do_wr(4'h4, 32'h0000_317F, 1'b1, "R3");
        run(120, 4'h0, 1'b1, "R3");
        // R11 counter wraps, then mixed pseudo-random traffic
        do_wr(4'h4, 32'h0000_017F, 1'b1, "R11");
        do_wr(4'h0, 32'h0000_0042, 1'b1, "R11");
        run(400, 4'h0, 1'b1, "R11");
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] ra;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ra = {lfsr[3:2] == 2'd3 ? 2'd0 : lfsr[3:2], lfsr[4], 1'b0};
            cur_req = "R11";
            addr = ra;
            word_acc = lfsr[5];
            wdata = {18'd0, lfsr[13:12] & {lfsr[20], 1'b1}, 3'd0, lfsr[8], lfsr[7] | lfsr[9], lfsr[6:0] | 7'h40};
            wr_en = (lfsr[11:9] == 3'd0) && (lfsr[15:14] != 2'd0);
            @(posedge clk); #1;
            wr_en = 1'b0;
        end
        run(4, 4'h0, 1'b1, "R11");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule